// File: doc/BRIEF.md
# Two-Point ADC Calibration Corrector

This block turns a raw 12-bit converter code into a corrected reading in engineering units (millivolts). Each of sixteen input channels has its own two-point correction built from a pair of factory trim deltas. After reset the block runs an initialisation pass. It fetches the lower and the upper trim delta of every calibrated channel through a simple request/acknowledge trim port. From the deltas it derives a gain-error divisor, a scale gain and an offset, and it stores the three words in a per-channel table.

At run time a client presents a channel number and a raw code while the block is not busy. The block removes the offset and divides by the gain-error term. A negative intermediate is clamped to zero and flagged as a calibration mismatch. Otherwise the intermediate is multiplied by the channel gain and divided by 1000. Channels without trim data bypass the offset and gain-error step and return the raw code. All divisions share one serial signed divider that truncates toward zero.

Top module: `adc_cal_corrector`

## Requirements
- R1: After reset `busy` stays high while the block visits channels 0 to 15 in ascending order. For each calibrated channel it raises `trim_req` first with the lower trim index and then with the upper index, and holds `trim_req` and `trim_idx` steady until `trim_ack`. Channels 11, 12, 13 and 15 are skipped. The index pairs are: channels 0, 1, 3, 4 and 5 use 1/2; channel 2 uses 3/4; channel 6 uses 5/6; channel 7 uses 7/8; channel 8 uses 9/10; channel 9 uses 11/12; channel 10 uses 13/14; channel 14 uses 15/16. `busy` falls once the last channel is done.
- R2: `trim_data` is a signed two's-complement byte. With lower delta d1 and upper delta d2, the gain-error divisor is k = 1000 + trunc(1000·(d2−d1)/(3112−2064)).
- R3: The channel gain is g = trunc(1000·(vH−vL)/1048). The (vL, vH) pairs in mV are: channels 0, 1, 3, 4 and 5 use (630, 950); channel 2 uses (1260, 1900); channels 6 and 7 use (2520, 3800); channel 8 uses (3150, 4750); channel 9 uses (5670, 8550); channel 10 uses (3465, 5225); channel 14 uses (3645, 5225).
- R4: The offset is d1·1000 − (k−1000)·2064. For a calibrated channel the intermediate is q = trunc((raw·1000 − offset)/k), and a non-negative q yields `res_value` = trunc(q·g/1000). All truncation is toward zero.
- R5: If q is negative, `res_value` is 0 and `res_mismatch` is 1. If q is zero or positive, including a small negative numerator that truncates to zero, `res_mismatch` is 0.
- R6: For channels 11, 12, 13 and 15, `res_value` equals the raw code and `res_mismatch` is 0.
- R7: A request is taken only on a cycle with `req_valid` high and `busy` low, and `busy` is high on the next cycle. A request made while `busy` is high produces no result and does not change the result of the conversion in progress.
- R8: Each accepted request produces exactly one single-cycle `res_valid` pulse, no more than 80 cycles after the accepting edge. No pulse appears without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | 4 | Channel of the request |
| req_raw | input | 12 | Raw converter code |
| busy | output | 1 | High during initialisation and while a conversion runs |
| res_valid | output | 1 | Single-cycle result strobe |
| res_value | output | 32 | Corrected value (signed, never negative) |
| res_mismatch | output | 1 | Intermediate was negative; value clamped to zero |
| trim_req | output | 1 | Trim fetch request, held until acknowledged |
| trim_idx | output | 5 | Trim register index being fetched |
| trim_ack | input | 1 | Trim fetch completion strobe |
| trim_data | input | 8 | Signed trim delta, valid with trim_ack |

## Verification
The properties assume that `trim_ack` is pulsed only while `trim_req` is high, and that `req_chan` stays below sixteen. They also assume that trim deltas stay within a signed byte, which keeps the gain-error divisor between 757 and 1243 and therefore never zero. The bench's trim responder acknowledges only a pending request, with a delay that rotates through zero to three cycles. It returns values from a fixed index table that covers the extreme bytes −128 and 127. Requests are driven only with legal channel numbers and 12-bit codes. Stray requests are deliberately issued while the block is busy.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  localparam int DATA_W = 32;

  typedef logic signed [DATA_W-1:0] cal_word_t;

  typedef struct packed {
    cal_word_t k;
    cal_word_t gain;
    cal_word_t offset;
  } cal_entry_t;

  // channels without factory trim data
  function automatic bit chan_has_trim(int ch);
    return !(ch == 11 || ch == 12 || ch == 13 || ch == 15 || ch > 15);
  endfunction

  // lower trim index; the upper one always follows it
  function automatic int chan_trim_lo(int ch);
    case (ch)
      0, 1, 3, 4, 5: return 1;
      2:             return 3;
      6:             return 5;
      7:             return 7;
      8:             return 9;
      9:             return 11;
      10:            return 13;
      14:            return 15;
      default:       return 0;
    endcase
  endfunction

  function automatic int chan_mv_lo(int ch);
    case (ch)
      0, 1, 3, 4, 5: return 630;
      2:             return 1260;
      6, 7:          return 2520;
      8:             return 3150;
      9:             return 5670;
      10:            return 3465;
      14:            return 3645;
      default:       return 0;
    endcase
  endfunction

  function automatic int chan_mv_hi(int ch);
    case (ch)
      0, 1, 3, 4, 5: return 950;
      2:             return 1900;
      6, 7:          return 3800;
      8:             return 4750;
      9:             return 8550;
      10, 14:        return 5225;
      default:       return 0;
    endcase
  endfunction

endpackage

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dvd, dsr, rem;
  logic [CW-1:0] cnt;
  logic          run, neg;
  logic [W-1:0]  num_mag, den_mag;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          fits;
  logic [W-1:0]  qnext;

  assign num_mag = num[W-1] ? (~num + 1'b1) : num;
  assign den_mag = den[W-1] ? (~den + 1'b1) : den;
  assign trial   = {rem, dvd[W-1]};
  assign fits    = trial >= {1'b0, dsr};
  assign diff    = trial[W-1:0] - dsr;
  assign qnext   = {dvd[W-2:0], fits};

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      dvd  <= '0;
      dsr  <= '0;
      rem  <= '0;
      neg  <= 1'b0;
      quo  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        dvd <= num_mag;
        dsr <= den_mag;
        rem <= '0;
        neg <= num[W-1] ^ den[W-1];
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff : trial[W-1:0];
        dvd <= qnext;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
          quo  <= neg ? (~qnext + 1'b1) : qnext;
        end
      end
    end
  end

  AST_DIV_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run)) else $error("divider done without a running divide"); // R8
  AST_DIV_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    start |-> !run) else $error("divide started while another runs"); // R8

endmodule

// File: rtl/adc_cal_table.sv
module adc_cal_table #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 96,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
  import adc_cal_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int RAW_W  = 12,
  parameter int TRIM_W = 8,
  parameter int TIDX_W = 5,
  parameter int X_LO   = 2064,
  parameter int X_HI   = 3112,
  parameter int UNIT   = 1000,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [RAW_W-1:0]  req_raw,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_value,
  output logic              res_mismatch,
  output logic              trim_req,
  output logic [TIDX_W-1:0] trim_idx,
  input  logic              trim_ack,
  input  logic [TRIM_W-1:0] trim_data
);
  localparam cal_word_t UNIT_W = cal_word_t'(UNIT);
  localparam cal_word_t XLO_W  = cal_word_t'(X_LO);
  localparam cal_word_t SPAN_W = cal_word_t'(X_HI - X_LO);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  typedef enum logic [3:0] {
    ST_INIT_CH, ST_TRIM_LO, ST_TRIM_HI, ST_K_GO, ST_K_WAIT, ST_G_GO,
    ST_G_WAIT, ST_INIT_WR, ST_IDLE, ST_COR_GO, ST_COR_WAIT, ST_SCL_GO,
    ST_SCL_WAIT
  } state_t;

  state_t                   st;
  logic [CH_W-1:0]          ch_q;
  logic signed [TRIM_W-1:0] d1_q, d2_q;
  cal_word_t                k_q, gain_q, qint_q;
  logic [RAW_W-1:0]         raw_q;

  cal_word_t  raw_ext, d1_ext, d2_ext, offset_calc, gain_sel;
  cal_word_t  div_num, div_den, div_quo;
  logic       div_start, div_done, cur_cal;
  cal_entry_t wr_entry, rd_entry;
  logic [$bits(cal_entry_t)-1:0] rd_bits;

  assign raw_ext     = cal_word_t'({{(DATA_W-RAW_W){1'b0}}, raw_q});
  assign d1_ext      = cal_word_t'(d1_q);
  assign d2_ext      = cal_word_t'(d2_q);
  assign cur_cal     = chan_has_trim(int'(ch_q));
  assign offset_calc = d1_ext * UNIT_W - (k_q - UNIT_W) * XLO_W;
  assign rd_entry    = cal_entry_t'(rd_bits);
  assign gain_sel    = cur_cal ? rd_entry.gain : UNIT_W;
  assign wr_entry    = '{k: k_q, gain: gain_q, offset: offset_calc};

  assign busy     = (st != ST_IDLE);
  assign trim_req = (st == ST_TRIM_LO) || (st == ST_TRIM_HI);

  always_comb begin
    trim_idx = TIDX_W'(chan_trim_lo(int'(ch_q)));
    if (st == ST_TRIM_HI) trim_idx = TIDX_W'(chan_trim_lo(int'(ch_q)) + 1);
  end

  // operand selection for the shared divider
  always_comb begin
    div_num   = '0;
    div_den   = UNIT_W;
    div_start = 1'b0;
    unique case (st)
      ST_K_GO: begin
        div_num   = (d2_ext - d1_ext) * UNIT_W;
        div_den   = SPAN_W;
        div_start = 1'b1;
      end
      ST_G_GO: begin
        div_num   = cal_word_t'(chan_mv_hi(int'(ch_q)) - chan_mv_lo(int'(ch_q))) * UNIT_W;
        div_den   = SPAN_W;
        div_start = 1'b1;
      end
      ST_COR_GO: begin
        div_num   = raw_ext * UNIT_W - rd_entry.offset;
        div_den   = rd_entry.k;
        div_start = cur_cal;
      end
      ST_SCL_GO: begin
        div_num   = qint_q * gain_sel;
        div_den   = UNIT_W;
        div_start = 1'b1;
      end
      default: ;
    endcase
  end

  adc_cal_div #(.W(DATA_W)) div_i (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_quo)
  );

  adc_cal_table #(.DEPTH(NCH), .WIDTH($bits(cal_entry_t))) table_i (
    .clk   (clk),
    .we    (st == ST_INIT_WR),
    .waddr (ch_q),
    .wdata (wr_entry),
    .re    ((st == ST_IDLE) && req_valid),
    .raddr (req_chan),
    .rdata (rd_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_INIT_CH;
      ch_q         <= '0;
      d1_q         <= '0;
      d2_q         <= '0;
      k_q          <= '0;
      gain_q       <= '0;
      qint_q       <= '0;
      raw_q        <= '0;
      res_valid    <= 1'b0;
      res_value    <= '0;
      res_mismatch <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_INIT_CH: begin
          if (cur_cal)              st <= ST_TRIM_LO;
          else if (ch_q == LAST_CH) st <= ST_IDLE;
          else                      ch_q <= ch_q + CH_W'(1);
        end
        ST_TRIM_LO: if (trim_ack) begin
          d1_q <= trim_data;
          st   <= ST_TRIM_HI;
        end
        ST_TRIM_HI: if (trim_ack) begin
          d2_q <= trim_data;
          st   <= ST_K_GO;
        end
        ST_K_GO:   st <= ST_K_WAIT;
        ST_K_WAIT: if (div_done) begin
          k_q <= UNIT_W + div_quo;
          st  <= ST_G_GO;
        end
        ST_G_GO:   st <= ST_G_WAIT;
        ST_G_WAIT: if (div_done) begin
          gain_q <= div_quo;
          st     <= ST_INIT_WR;
        end
        ST_INIT_WR: begin
          if (ch_q == LAST_CH) st <= ST_IDLE;
          else begin
            ch_q <= ch_q + CH_W'(1);
            st   <= ST_INIT_CH;
          end
        end
        ST_IDLE: if (req_valid) begin
          ch_q  <= req_chan;
          raw_q <= req_raw;
          st    <= ST_COR_GO;
        end
        ST_COR_GO: begin
          if (cur_cal) st <= ST_COR_WAIT;
          else begin
            qint_q <= raw_ext;
            st     <= ST_SCL_GO;
          end
        end
        ST_COR_WAIT: if (div_done) begin
          if (div_quo[DATA_W-1]) begin
            res_valid    <= 1'b1;
            res_value    <= '0;
            res_mismatch <= 1'b1;
            st           <= ST_IDLE;
          end else begin
            qint_q <= div_quo;
            st     <= ST_SCL_GO;
          end
        end
        ST_SCL_GO:   st <= ST_SCL_WAIT;
        ST_SCL_WAIT: if (div_done) begin
          res_valid    <= 1'b1;
          res_value    <= div_quo;
          res_mismatch <= 1'b0;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    trim_req && !trim_ack |=> trim_req && $stable(trim_idx)) else $error("trim request dropped"); // R1
  AST_TRIM_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !trim_req) else $error("trim fetch while idle"); // R1
  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy |=> busy) else $error("accepted request left block idle"); // R7
  AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_mismatch |-> res_value == '0) else $error("mismatch with nonzero value"); // R5
  AST_RES_NONNEG: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !res_value[DATA_W-1]) else $error("negative result"); // R5
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid) else $error("result strobe longer than a cycle"); // R8

endmodule

// File: tb/adc_cal_corrector_tb.sv
module adc_cal_corrector_tb_top;
  localparam int CH_W   = 4;
  localparam int RAW_W  = 12;
  localparam int TRIM_W = 8;
  localparam int TIDX_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [CH_W-1:0]   req_chan = '0;
  logic [RAW_W-1:0]  req_raw = '0;
  logic              busy, res_valid, res_mismatch, trim_req;
  logic [31:0]       res_value;
  logic [TIDX_W-1:0] trim_idx;
  logic              trim_ack = 1'b0;
  logic [TRIM_W-1:0] trim_data = '0;

  int  n_checks = 0;
  int  n_errs = 0;
  int  outstanding = 0;
  bit  finished = 0;
  int  trim_mem [32];
  int  idx_log [$];

  always #10 clk = ~clk;

  adc_cal_corrector dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_raw(req_raw), .busy(busy), .res_valid(res_valid),
    .res_value(res_value), .res_mismatch(res_mismatch),
    .trim_req(trim_req), .trim_idx(trim_idx), .trim_ack(trim_ack),
    .trim_data(trim_data)
  );

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit tb_cal(int ch);
    return !(ch == 11 || ch == 12 || ch == 13 || ch == 15);
  endfunction

  function automatic int tb_lo_idx(int ch);
    case (ch)
      0, 1, 3, 4, 5: return 1;
      2: return 3;  6: return 5;  7: return 7;  8: return 9;
      9: return 11; 10: return 13; 14: return 15;
      default: return 0;
    endcase
  endfunction

  function automatic int tb_vlo(int ch);
    case (ch)
      2: return 1260; 6, 7: return 2520; 8: return 3150;
      9: return 5670; 10: return 3465; 14: return 3645;
      default: return 630;
    endcase
  endfunction

  function automatic int tb_vhi(int ch);
    case (ch)
      2: return 1900; 6, 7: return 3800; 8: return 4750;
      9: return 8550; 10, 14: return 5225;
      default: return 950;
    endcase
  endfunction

  function automatic int tb_expect(int ch, int raw, output bit mm);
    int d1, d2, k, g, off, q;
    mm = 1'b0;
    if (!tb_cal(ch)) return raw;                       // R6
    d1  = trim_mem[tb_lo_idx(ch)];
    d2  = trim_mem[tb_lo_idx(ch) + 1];
    k   = 1000 + (1000 * (d2 - d1)) / 1048;            // R2
    g   = ((tb_vhi(ch) - tb_vlo(ch)) * 1000) / 1048;   // R3
    off = d1 * 1000 - (k - 1000) * 2064;               // R4
    q   = (raw * 1000 - off) / k;
    if (q < 0) begin
      mm = 1'b1;                                       // R5
      return 0;
    end
    return (q * g) / 1000;
  endfunction

  // trim port responder with a rotating delay
  initial begin : responder
    int dly;
    dly = 0;
    forever begin
      @(negedge clk);
      if (!rst && trim_req) begin
        repeat (dly) @(negedge clk);
        trim_data = TRIM_W'(trim_mem[trim_idx]);
        trim_ack  = 1'b1;
        idx_log.push_back(int'(trim_idx));
        @(negedge clk);
        trim_ack = 1'b0;
        dly = (dly + 1) % 4;
      end
    end
  end

  // every clock: no result strobe without an outstanding request
  always @(negedge clk) begin
    if (!rst && res_valid && outstanding == 0)
      chk(1'b0, "R8", "result strobe without request", 1, 0);
  end

  task automatic convert(int ch, int raw, bit poke);
    int  ev, lat;
    bit  em;
    string tag;
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_chan  = CH_W'(ch);
    req_raw   = RAW_W'(raw);
    @(negedge clk);
    req_valid = 1'b0;
    outstanding = 1;
    lat = 1;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    if (poke) begin
      req_valid = 1'b1;
      req_chan  = CH_W'((ch + 3) % 16);
      req_raw   = RAW_W'(4095 - raw);
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end
    while (!res_valid && lat < 120) begin
      @(negedge clk);
      lat++;
    end
    ev = tb_expect(ch, raw, em);
    tag = !tb_cal(ch) ? "R6" : (em ? "R5" : "R2 R3 R4");
    chk(res_valid == 1'b1, "R8", "result strobe seen", res_valid, 1);
    chk(lat <= 80, "R8", "latency bound", lat, 80);
    chk(res_value == 32'(ev), tag, $sformatf("value ch%0d raw%0d", ch, raw),
        longint'($signed(res_value)), ev);
    chk(res_mismatch == em, "R5", $sformatf("mismatch ch%0d raw%0d", ch, raw),
        res_mismatch, em);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8", "single-cycle strobe", res_valid, 0);
    outstanding = 0;
  endtask

  initial begin : main
    int w;
    int exp_seq [$];
    for (int i = 0; i < 32; i++) trim_mem[i] = 0;
    trim_mem[1] = 100;  trim_mem[2] = 100;  trim_mem[3] = -20;  trim_mem[4] = 15;
    trim_mem[5] = 5;    trim_mem[6] = -7;   trim_mem[7] = -128; trim_mem[8] = 127;
    trim_mem[9] = 0;    trim_mem[10] = 0;   trim_mem[11] = 60;  trim_mem[12] = -60;
    trim_mem[13] = -3;  trim_mem[14] = 40;  trim_mem[15] = 127; trim_mem[16] = -128;

    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R1", "busy during reset", busy, 1);
    chk(res_valid == 1'b0, "R8", "no strobe in reset", res_valid, 0);
    rst = 1'b0;

    w = 0;
    while (busy && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(busy == 1'b0, "R1", "initialisation finishes", busy, 0);
    for (int ch = 0; ch < 16; ch++)
      if (tb_cal(ch)) begin
        exp_seq.push_back(tb_lo_idx(ch));
        exp_seq.push_back(tb_lo_idx(ch) + 1);
      end
    chk(idx_log.size() == exp_seq.size(), "R1", "trim fetch count",
        idx_log.size(), exp_seq.size());
    for (int i = 0; i < exp_seq.size() && i < idx_log.size(); i++)
      chk(idx_log[i] == exp_seq[i], "R1", $sformatf("trim index #%0d", i),
          idx_log[i], exp_seq[i]);

    // mid-scale and boundary codes on calibrated channels
    convert(0, 2500, 0);
    convert(0, 100, 0);      // numerator exactly zero
    convert(0, 99, 0);       // just negative
    convert(0, 0, 0);
    convert(9, 295, 0);      // small negative numerator truncates to zero
    convert(9, 294, 0);
    convert(14, 0, 0);       // smallest divisor, negative
    convert(14, 4095, 0);
    convert(7, 4095, 0);     // largest divisor
    convert(7, 0, 0);
    // uncalibrated bypass
    convert(11, 1234, 0);
    convert(12, 0, 0);
    convert(13, 4095, 0);
    convert(15, 77, 0);
    // stray requests while busy must be ignored
    convert(2, 3000, 1);
    convert(11, 500, 1);
    repeat (100) @(negedge clk);
    // sweep every channel
    for (int ch = 0; ch < 16; ch++)
      convert(ch, (ch * 271 + 13) % 4096, 0);
    for (int ch = 0; ch < 16; ch++)
      convert(ch, 4095 - ch * 97, 0);

    repeat (10) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule